// File: doc/BRIEF.md
# Oversampling Asynchronous Character Receiver

This block turns a start/stop framed serial line into parallel characters. It works from a receive clock that the surrounding logic supplies as a one-cycle enable pulse on the system clock. That receive clock runs at one, sixteen or sixty-four times the bit rate. In the two oversampled modes the receiver confirms a falling edge by looking at the line again half a bit later. After that it takes each data bit, the optional parity bit and the first stop bit at the centre of its cell, least significant data bit first.

A finished character moves into a holding register, where a CPU reads it. This lets the next character arrive while the previous one waits to be read. Parity errors and framing errors travel with the character they belong to. An overrun is flagged when a character lands on an unread one. A line held low through a whole character raises a break indication, which stays up until the line goes high again.

Top module: `async_rx_core`

## Requirements
- R1: After a synchronous active-low reset, `rx_ready`, `err_frame`, `err_parity`, `err_overrun` and `brk_det` are all 0.
- R2: `len_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. The character appears right-justified on `rx_data` with all unused upper bits 0.
- R3: `os_sel` sets the receive clock factor: 0 gives x1, 1 gives x16, and 2 or 3 give x64. With factor F > 1, data is sampled F/2 + k·F receive ticks after the first low tick, for k ≥ 1. In x1 mode the first low tick is taken as the start bit and every following tick samples one bit.
- R4: In x16 and x64 modes, the receiver goes back to hunting for a start bit if the line is high at the half-bit check. No character is delivered and `rx_ready` does not change.
- R5: When `par_en` is 1, a parity bit follows the data. It is checked as even when `par_odd` is 0 and as odd when `par_odd` is 1. A mismatch sets `err_parity` for that character. When `par_en` is 0, `err_parity` is 0.
- R6: Only the first stop bit is checked. If it is sampled low, `err_frame` is 1 for that character; if it is high, `err_frame` is 0.
- R7: `rx_ready` rises when a character is delivered and falls after a one-cycle `rd_stb`. `rx_data` keeps the character after it has been read.
- R8: If a character is delivered while `rx_ready` is still 1, `err_overrun` is set and `rx_data` holds the newer character. `rd_stb` clears `err_overrun`.
- R9: `brk_det` goes to 1 when every sample of a character is low, the stop sample included. It returns to 0 on the first receive tick on which the line is high. The character it belongs to is delivered with `rx_data` equal to 0 and `err_frame` equal to 1.
- R10: After a low stop sample, no new start bit is accepted until the line has been high for at least one receive tick. A line held low therefore yields exactly one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | One-cycle pulse per receive clock edge |
| rx_line | input | 1 | Serial data in, already synchronised, idles high |
| os_sel | input | 2 | Receive clock factor (0: x1, 1: x16, 2/3: x64) |
| len_sel | input | 2 | Data length minus five |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_stb | input | 1 | CPU read strobe, one cycle |
| rx_data | output | 8 | Received character, right-justified |
| rx_ready | output | 1 | Holding register holds an unread character |
| err_frame | output | 1 | Stop bit of the held character was low |
| err_parity | output | 1 | Parity of the held character was wrong |
| err_overrun | output | 1 | An unread character was overwritten |
| brk_det | output | 1 | Break condition on the line |

## Verification
The assertions assume that `os_sel`, `len_sel`, `par_en` and `par_odd` change only while the receiver is idle. The sample counter bound and the parity check depend on that. They also assume `rx_tick` is a single-cycle pulse. The stimulus follows these rules. It changes the mode only after the line has been idle for at least two bit times. It produces every receive tick as one high cycle followed by one low cycle, and it moves `rx_line` only while `rx_tick` is low.

// File: rtl/arx_pkg.sv
// Shared constants and types for the asynchronous receiver.
// Assumes: at most 8 data bits per character.
package arx_pkg;
    localparam int ARX_MAX_BITS = 8;
    localparam int ARX_IDX_W    = 4;
    localparam int ARX_SEL_W    = $clog2(ARX_MAX_BITS);

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_VALID = 2'd1,
        ST_FRAME = 2'd2,
        ST_LOWWT = 2'd3
    } arx_state_e;

    typedef struct packed {
        logic [ARX_MAX_BITS-1:0] data;
        logic                    frame_err;
        logic                    par_err;
    } arx_char_t;
endpackage

// File: rtl/arx_sampler.sv
// Bit timing for the receiver. Hunts for a start bit, validates it at
// half a bit time when oversampling, then issues one centre sample per
// bit cell until the frame is complete.
// Assumes: rx_tick is a single-cycle pulse; mode inputs change only in hunt.
module arx_sampler
    import arx_pkg::*;
#(
    parameter int FAC_MID  = 16,
    parameter int FAC_HIGH = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_tick,
    input  logic                 rx_line,
    input  logic [1:0]           os_sel,
    input  logic [ARX_IDX_W-1:0] frame_bits,
    output logic                 samp_vld,
    output logic                 samp_bit,
    output logic                 samp_last,
    output logic                 frame_start,
    output logic                 line_rel
);
    localparam int CNT_W = $clog2(FAC_HIGH);

    arx_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] fac_m1;
    logic [CNT_W-1:0] half_m1;
    logic [ARX_IDX_W-1:0] bit_idx;

    // Decode the clock factor into terminal counts.
    always_comb begin
        case (os_sel)
            2'd0: begin
                fac_m1  = '0;
                half_m1 = '0;
            end
            2'd1: begin
                fac_m1  = CNT_W'(FAC_MID - 1);
                half_m1 = CNT_W'(FAC_MID / 2 - 1);
            end
            default: begin
                fac_m1  = CNT_W'(FAC_HIGH - 1);
                half_m1 = CNT_W'(FAC_HIGH / 2 - 1);
            end
        endcase
    end

    // Sequence hunt, validation, per-bit sampling and wait-for-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_HUNT;
            cnt         <= '0;
            bit_idx     <= '0;
            samp_vld    <= 1'b0;
            samp_bit    <= 1'b1;
            samp_last   <= 1'b0;
            frame_start <= 1'b0;
            line_rel    <= 1'b0;
        end else begin
            samp_vld    <= 1'b0;
            samp_last   <= 1'b0;
            frame_start <= 1'b0;
            line_rel    <= 1'b0;
            if (rx_tick) begin
                case (st)
                    ST_HUNT: begin
                        if (!rx_line) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            if (os_sel == 2'd0) begin
                                st          <= ST_FRAME;
                                frame_start <= 1'b1;
                            end else begin
                                st <= ST_VALID;
                            end
                        end
                    end
                    ST_VALID: begin
                        if (cnt == half_m1) begin
                            cnt <= '0;
                            if (rx_line) begin
                                st <= ST_HUNT;
                            end else begin
                                st          <= ST_FRAME;
                                frame_start <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_FRAME: begin
                        if (cnt == fac_m1) begin
                            cnt      <= '0;
                            samp_vld <= 1'b1;
                            samp_bit <= rx_line;
                            bit_idx  <= bit_idx + 1'b1;
                            if (bit_idx == frame_bits - 1'b1) begin
                                samp_last <= 1'b1;
                                st        <= rx_line ? ST_HUNT : ST_LOWWT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (rx_line) begin
                            st       <= ST_HUNT;
                            line_rel <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R3: the sample counter never passes the selected factor.
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= fac_m1);
    // R3: a sample is only produced in response to a receive tick.
    assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |-> $past(rx_tick));
    // R4: a frame only starts from a low line.
    assert_start_from_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !$past(rx_line));
endmodule

// File: rtl/arx_framer.sv
// Character assembly. Places data samples by position, captures the
// parity sample, evaluates parity and stop, and tracks break.
// Assumes: mode inputs are stable for the length of a character.
module arx_framer
    import arx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           len_sel,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 samp_vld,
    input  logic                 samp_bit,
    input  logic                 samp_last,
    input  logic                 frame_start,
    input  logic                 line_rel,
    output logic [ARX_IDX_W-1:0] frame_bits,
    output logic                 done,
    output arx_char_t            done_char,
    output logic                 brk
);
    logic [ARX_IDX_W-1:0]    nbits;
    logic [ARX_IDX_W-1:0]    idx;
    logic [ARX_MAX_BITS-1:0] data_q;
    logic                    par_q;
    logic                    all_low;
    logic                    par_bad;

    // Derive data length and total samples after the start bit.
    always_comb begin
        nbits      = ARX_IDX_W'(5) + ARX_IDX_W'(len_sel);
        frame_bits = nbits + ARX_IDX_W'(par_en) + ARX_IDX_W'(1);
        par_bad    = par_en && ((^data_q ^ par_q) != par_odd);
    end

    // Assemble the character and publish it on the stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            data_q    <= '0;
            par_q     <= 1'b0;
            all_low   <= 1'b1;
            done      <= 1'b0;
            done_char <= '0;
            brk       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (frame_start) begin
                idx     <= '0;
                data_q  <= '0;
                par_q   <= 1'b0;
                all_low <= 1'b1;
            end else if (samp_vld) begin
                idx     <= idx + 1'b1;
                all_low <= all_low & ~samp_bit;
                if (idx < nbits) begin
                    data_q[idx[ARX_SEL_W-1:0]] <= samp_bit;
                end else if (par_en && (idx == nbits)) begin
                    par_q <= samp_bit;
                end
                if (samp_last) begin
                    done                <= 1'b1;
                    done_char.data      <= data_q;
                    done_char.frame_err <= ~samp_bit;
                    done_char.par_err   <= par_bad;
                    if (!samp_bit && all_low) begin
                        brk <= 1'b1;
                    end
                end
            end
            if (line_rel) begin
                brk <= 1'b0;
            end
        end
    end

    // R9: break only appears with a delivered, badly framed character.
    assert_break_with_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk) |-> (done && done_char.frame_err));
    // R5: no parity error is reported while parity is off.
    assert_no_par_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !par_en) |-> !done_char.par_err);
endmodule

// File: rtl/arx_holdbuf.sv
// Holding register between the assembler and the CPU. Keeps the last
// character and its error flags, and tracks unread and overrun state.
// Assumes: rd_stb is a single-cycle pulse.
module arx_holdbuf
    import arx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      done,
    input  arx_char_t done_char,
    input  logic      rd_stb,
    output arx_char_t held,
    output logic      ready,
    output logic      overrun
);
    // Load new characters, clear occupancy on read, flag overwrites.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= '0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else if (done) begin
            held    <= done_char;
            ready   <= 1'b1;
            overrun <= (ready | overrun) & ~rd_stb;
        end else if (rd_stb) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
        end
    end

    // R8: overrun only rises when an unread character was present.
    assert_overrun_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(ready));
    // R7: a read with no simultaneous delivery empties the buffer.
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> (!ready && !overrun));
endmodule

// File: rtl/async_rx_core.sv
// Top of the asynchronous receiver: sampler, assembler and holding
// register in a chain.
// Assumes: rx_line is synchronised to clk; rx_tick marks receive clock edges.
module async_rx_core
    import arx_pkg::*;
#(
    parameter int FAC_MID  = 16,
    parameter int FAC_HIGH = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_tick,
    input  logic                    rx_line,
    input  logic [1:0]              os_sel,
    input  logic [1:0]              len_sel,
    input  logic                    par_en,
    input  logic                    par_odd,
    input  logic                    rd_stb,
    output logic [ARX_MAX_BITS-1:0] rx_data,
    output logic                    rx_ready,
    output logic                    err_frame,
    output logic                    err_parity,
    output logic                    err_overrun,
    output logic                    brk_det
);
    logic [ARX_IDX_W-1:0] frame_bits;
    logic                 samp_vld;
    logic                 samp_bit;
    logic                 samp_last;
    logic                 frame_start;
    logic                 line_rel;
    logic                 done;
    arx_char_t            done_char;
    arx_char_t            held;

    arx_sampler #(.FAC_MID(FAC_MID), .FAC_HIGH(FAC_HIGH)) u_samp (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
        .os_sel(os_sel), .frame_bits(frame_bits), .samp_vld(samp_vld),
        .samp_bit(samp_bit), .samp_last(samp_last),
        .frame_start(frame_start), .line_rel(line_rel)
    );

    arx_framer u_frm (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .par_en(par_en),
        .par_odd(par_odd), .samp_vld(samp_vld), .samp_bit(samp_bit),
        .samp_last(samp_last), .frame_start(frame_start),
        .line_rel(line_rel), .frame_bits(frame_bits), .done(done),
        .done_char(done_char), .brk(brk_det)
    );

    arx_holdbuf u_hold (
        .clk(clk), .rst_n(rst_n), .done(done), .done_char(done_char),
        .rd_stb(rd_stb), .held(held), .ready(rx_ready),
        .overrun(err_overrun)
    );

    // Present the held character and its flags.
    always_comb begin
        rx_data    = held.data;
        err_frame  = held.frame_err;
        err_parity = held.par_err;
    end
endmodule

// File: tb/sim_async_rx_core.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_async_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] os_sel = 2'd1;
    logic [1:0] len_sel = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_frame, err_parity, err_overrun, brk_det;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    async_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
        .os_sel(os_sel), .len_sel(len_sel), .par_en(par_en),
        .par_odd(par_odd), .rd_stb(rd_stb), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun),
        .brk_det(brk_det)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int fac();
        return (os_sel == 2'd0) ? 1 : (os_sel == 2'd1) ? 16 : 64;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rx_tick = 1'b1;
            @(negedge clk) rx_tick = 1'b0;
        end
    endtask

    task automatic hold_line(input logic v, input int bits);
        rx_line = v;
        tick(bits * fac());
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        settle();
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input logic stop_v);
        int n;
        logic p;
        n = 5 + int'(len_sel);
        p = par_odd;
        for (int i = 0; i < n; i++) p = p ^ d[i];
        hold_line(1'b0, 1);
        for (int i = 0; i < n; i++) hold_line(d[i], 1);
        if (par_en) hold_line(p ^ bad_par, 1);
        hold_line(stop_v, 1);
        hold_line(1'b1, 2);
        settle();
    endtask

    task automatic set_mode(input logic [1:0] os, input logic [1:0] ln,
                            input logic pe, input logic po);
        os_sel = os; len_sel = ln; par_en = pe; par_odd = po;
        hold_line(1'b1, 2);
    endtask

    task automatic t_reset();
        chk("R1", "ready", rx_ready, 0);
        chk("R1", "overrun", err_overrun, 0);
        chk("R1", "frame", err_frame, 0);
        chk("R1", "parity", err_parity, 0);
        chk("R1", "break", brk_det, 0);
    endtask

    task automatic t_x16_8bit();
        set_mode(2'd1, 2'd3, 1'b0, 1'b0);
        send(8'hA5, 1'b0, 1'b1);
        chk("R3", "x16 data", rx_data, 8'hA5);
        chk("R7", "ready set", rx_ready, 1);
        chk("R6", "frame clear", err_frame, 0);
        chk("R5", "parity off", err_parity, 0);
        do_read();
        chk("R7", "ready after read", rx_ready, 0);
        chk("R7", "data kept", rx_data, 8'hA5);
    endtask

    task automatic t_x64_7bit_even();
        set_mode(2'd2, 2'd2, 1'b1, 1'b0);
        send(8'h5A, 1'b0, 1'b1);
        chk("R3", "x64 7-bit data", rx_data, 8'h5A);
        chk("R5", "even parity ok", err_parity, 0);
        do_read();
    endtask

    task automatic t_x1_5bit_odd();
        set_mode(2'd0, 2'd0, 1'b1, 1'b1);
        send(8'hF3, 1'b0, 1'b1);
        chk("R2", "x1 5-bit data", rx_data, 8'h13);
        chk("R5", "odd parity ok", err_parity, 0);
        do_read();
    endtask

    task automatic t_6bit_upper_zero();
        set_mode(2'd1, 2'd1, 1'b0, 1'b0);
        send(8'hEA, 1'b0, 1'b1);
        chk("R2", "6-bit upper zero", rx_data, 8'h2A);
        do_read();
    endtask

    task automatic t_parity_error();
        set_mode(2'd1, 2'd3, 1'b1, 1'b0);
        send(8'h3C, 1'b1, 1'b1);
        chk("R5", "parity error", err_parity, 1);
        chk("R5", "data with bad parity", rx_data, 8'h3C);
        do_read();
    endtask

    task automatic t_frame_error();
        set_mode(2'd1, 2'd3, 1'b0, 1'b0);
        send(8'h81, 1'b0, 1'b0);
        chk("R6", "frame error", err_frame, 1);
        chk("R9", "no break with data", brk_det, 0);
        do_read();
    endtask

    task automatic t_false_start();
        set_mode(2'd1, 2'd3, 1'b0, 1'b0);
        rx_line = 1'b0; tick(5);
        hold_line(1'b1, 12);
        settle();
        chk("R4", "x16 false start", rx_ready, 0);
        set_mode(2'd2, 2'd3, 1'b0, 1'b0);
        rx_line = 1'b0; tick(20);
        hold_line(1'b1, 12);
        settle();
        chk("R4", "x64 false start", rx_ready, 0);
        send(8'h69, 1'b0, 1'b1);
        chk("R4", "char after false start", rx_data, 8'h69);
        do_read();
    endtask

    task automatic t_overrun();
        set_mode(2'd1, 2'd3, 1'b0, 1'b0);
        send(8'h11, 1'b0, 1'b1);
        chk("R8", "no overrun yet", err_overrun, 0);
        send(8'h22, 1'b0, 1'b1);
        chk("R8", "overrun set", err_overrun, 1);
        chk("R8", "newer data", rx_data, 8'h22);
        do_read();
        chk("R8", "overrun cleared", err_overrun, 0);
    endtask

    task automatic t_break();
        set_mode(2'd1, 2'd3, 1'b0, 1'b0);
        hold_line(1'b0, 13);
        settle();
        chk("R9", "break set", brk_det, 1);
        chk("R9", "break char data", rx_data, 0);
        chk("R9", "break frame err", err_frame, 1);
        do_read();
        hold_line(1'b0, 20);
        settle();
        chk("R10", "single char while low", rx_ready, 0);
        chk("R9", "break held while low", brk_det, 1);
        rx_line = 1'b1; tick(2);
        settle();
        chk("R9", "break released", brk_det, 0);
        hold_line(1'b1, 3);
        chk("R10", "no char after release", rx_ready, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_x16_8bit();
        t_x64_7bit_even();
        t_x1_5bit_odd();
        t_6bit_upper_zero();
        t_parity_error();
        t_frame_error();
        t_false_start();
        t_overrun();
        t_break();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule